// File: doc/BRIEF.md
# Load Fault Classifier with Short-Circuit Blanking

This block sorts the load faults of a bank of low-side switches, one channel at a time. For each channel it receives one digital comparator result, which is 1 when the switch output sits above the reference level. It also receives the channel's latched on/off command. The comparator result is read according to the command. An output that stays high while the switch is commanded on points to a shorted load. An output that falls low while the switch is commanded off points to a missing load.

The comparator lines come from the analogue domain without a clock. Each one passes through a synchronizer and then a filter that needs two agreeing samples before it moves, so single-sample noise is dropped. From the filtered levels the block produces, in registers, three things:
- a per-channel fault vector, which the serial shift logic loads on its next capture;
- an active-low short-circuit status pin;
- an active-low open-load status pin.

Whenever the command latch is rewritten, short-circuit reporting is suppressed for a programmable number of clocks, because the outputs are still switching. Suppression applies both to the status pin and to the short bits in the fault vector, so the two always agree. Open-load reporting is never suppressed.

Top module: `chfault_status`

## Requirements
- R1: When channel i is commanded on (cmd_on[i]=1) and its filtered comparator is 1 (output above reference), fault_vec[i] is 1 one clock after the command is applied, unless short blanking is active.
- R2: When channel i is commanded off (cmd_on[i]=0) and its filtered comparator is 0 (output below reference), fault_vec[i] is 1. With the default two synchronizer stages, a comparator change held steady reaches fault_vec on the fifth clock edge.
- R3: short_n is 0 in exactly the cycles in which at least one channel shows an unblanked short, and is 1 otherwise.
- R4: open_n is 0 in exactly the cycles in which at least one channel shows an open load, and is 1 otherwise.
- R5: A one-cycle pulse on latch_upd sampled at edge k forces every short bit of fault_vec to 0, and short_n to 1, in the outputs registered at edges k through k+BLANK_CYC-1. The outputs registered at edge k+BLANK_CYC report shorts again. Open-load bits and open_n are not affected by blanking.
- R6: Bit i of fault_vec belongs to channel i and is 0 when neither condition holds, including a channel that is on with its comparator at 0. When both status pins are 1, fault_vec is all zero.
- R7: A latch_upd pulse that arrives while blanking is active restarts the window, so it ends BLANK_CYC outputs after the newest pulse.
- R8: A comparator level that lasts only one clock never reaches the filtered state. A level that lasts two clocks does.
- R9: While rst is high, and in the first outputs after it is released, fault_vec is 0, short_n and open_n are 1, the filtered comparator state reads "above reference", and blanking is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_above | input | CHANNELS | Asynchronous comparator results, 1 = output above reference |
| cmd_on | input | CHANNELS | Latched switch commands, 1 = on |
| latch_upd | input | 1 | One-cycle pulse marking a command latch write |
| fault_vec | output | CHANNELS | Registered per-channel fault flags for the shift logic |
| short_n | output | 1 | Short-circuit status, low when any unblanked short exists |
| open_n | output | 1 | Open-load status, low when any open load exists |

## Verification
Two functions can land on the same clock edge: the end of a blanking window, and a fresh latch update that restarts that window. The bench provokes this by pulsing latch_upd in the cycle whose sample is the last masked output of the running window, while a short on one channel and an open load on another are both held. It then expects the short to stay hidden for a full new window, and to appear on exactly the edge that follows it. Throughout the window it expects the open-load bit and open_n to stay asserted.

// File: rtl/chfault_pkg.sv
package chfault_pkg;

  localparam int DEF_CHANNELS    = 8;
  localparam int DEF_BLANK_CYC   = 256;
  localparam int DEF_SYNC_STAGES = 2;

  // comparator edge to fault_vec edge count: sync stages, history, filter, output
  function automatic int cmp_latency(input int sync_stages);
    return sync_stages + 3;
  endfunction

  // counter width able to hold a reload value of limit-1
  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/chfault_cmp_filter.sv
module chfault_cmp_filter #(
  parameter int CHANNELS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] cmp_raw,
  output logic [CHANNELS-1:0] cmp_filt
);

  logic [CHANNELS-1:0] sync_q [SYNC_STAGES];
  logic [CHANNELS-1:0] hist_q;
  logic [CHANNELS-1:0] filt_q;
  logic [CHANNELS-1:0] agree;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= '1;
          else     sync_q[0] <= cmp_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= '1;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '1;
    else     hist_q <= sync_q[SYNC_STAGES-1];
  end

  assign agree = ~(sync_q[SYNC_STAGES-1] ^ hist_q);

  genvar c;
  generate
    for (c = 0; c < CHANNELS; c++) begin : g_filt
      always_ff @(posedge clk) begin
        if (rst)           filt_q[c] <= 1'b1;
        else if (agree[c]) filt_q[c] <= hist_q[c];
      end

      AST_FILT_NEEDS_AGREE: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q[c]) |-> $past(sync_q[SYNC_STAGES-1][c] == hist_q[c])); // R8
    end
  endgenerate

  assign cmp_filt = filt_q;

endmodule

// File: rtl/chfault_blank_timer.sv
module chfault_blank_timer #(
  parameter int BLANK_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  output logic blank
);

  localparam int CNT_W = chfault_pkg::cnt_width(BLANK_CYC);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BLANK_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (upd)         cnt_q <= RELOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign blank = upd | (cnt_q != '0);

  AST_BLANK_RESTART: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cnt_q == RELOAD)); // R7

  AST_BLANK_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (!upd && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/chfault_classify.sv
module chfault_classify #(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] cmp_filt,
  input  logic [CHANNELS-1:0] cmd_on,
  input  logic                blank,
  output logic [CHANNELS-1:0] fault_vec,
  output logic                short_n,
  output logic                open_n
);

  logic [CHANNELS-1:0] short_raw;
  logic [CHANNELS-1:0] short_vis;
  logic [CHANNELS-1:0] open_raw;
  logic [CHANNELS-1:0] fault_q;
  logic                short_n_q;
  logic                open_n_q;

  always_comb begin
    short_raw = cmp_filt & cmd_on;
    open_raw  = ~cmp_filt & ~cmd_on;
    short_vis = blank ? '0 : short_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q   <= '0;
      short_n_q <= 1'b1;
      open_n_q  <= 1'b1;
    end else begin
      fault_q   <= short_vis | open_raw;
      short_n_q <= ~(|short_vis);
      open_n_q  <= ~(|open_raw);
    end
  end

  assign fault_vec = fault_q;
  assign short_n   = short_n_q;
  assign open_n    = open_n_q;

  AST_SC_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !short_n_q |-> |(fault_q & $past(cmd_on))); // R3

  AST_OL_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !open_n_q |-> |(fault_q & ~$past(cmd_on))); // R4

  AST_BLANK_HIDES_SC: assert property (@(posedge clk) disable iff (rst)
    $past(blank) |-> (short_n_q && ((fault_q & $past(cmd_on)) == '0))); // R5

  AST_QUIET_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (short_n_q && open_n_q) |-> (fault_q == '0)); // R6

endmodule

// File: rtl/chfault_status.sv
module chfault_status #(
  parameter int CHANNELS    = chfault_pkg::DEF_CHANNELS,
  parameter int BLANK_CYC   = chfault_pkg::DEF_BLANK_CYC,
  parameter int SYNC_STAGES = chfault_pkg::DEF_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] cmp_above,
  input  logic [CHANNELS-1:0] cmd_on,
  input  logic                latch_upd,
  output logic [CHANNELS-1:0] fault_vec,
  output logic                short_n,
  output logic                open_n
);

  logic [CHANNELS-1:0] cmp_filt;
  logic                blank;

  chfault_cmp_filter #(
    .CHANNELS    (CHANNELS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_filter (
    .clk      (clk),
    .rst      (rst),
    .cmp_raw  (cmp_above),
    .cmp_filt (cmp_filt)
  );

  chfault_blank_timer #(
    .BLANK_CYC (BLANK_CYC)
  ) u_blank (
    .clk   (clk),
    .rst   (rst),
    .upd   (latch_upd),
    .blank (blank)
  );

  chfault_classify #(
    .CHANNELS (CHANNELS)
  ) u_class (
    .clk       (clk),
    .rst       (rst),
    .cmp_filt  (cmp_filt),
    .cmd_on    (cmd_on),
    .blank     (blank),
    .fault_vec (fault_vec),
    .short_n   (short_n),
    .open_n    (open_n)
  );

  AST_UPD_MASKS_PIN: assert property (@(posedge clk) disable iff (rst)
    $past(latch_upd) |-> short_n); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (fault_vec == '0 && short_n && open_n)); // R9

endmodule

// File: tb/chfault_status_tb.sv
module chfault_status_tb;

  localparam int N     = 8;
  localparam int BLANK = 256;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] cmp_above;
  logic [N-1:0] cmd_on;
  logic         latch_upd;
  logic [N-1:0] fault_vec;
  logic         short_n;
  logic         open_n;

  always #4 clk = ~clk;

  chfault_status #(
    .CHANNELS    (N),
    .BLANK_CYC   (BLANK),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .cmp_above (cmp_above),
    .cmd_on    (cmd_on),
    .latch_upd (latch_upd),
    .fault_vec (fault_vec),
    .short_n   (short_n),
    .open_n    (open_n)
  );

  typedef struct {
    int           due;
    string        tag;
    logic [N-1:0] fv;
    logic         sc;
    logic         ol;
  } exp_t;

  exp_t q[$];
  int   cyc    = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int due, input string tag, input logic [N-1:0] fv,
                      input logic sc, input logic ol);
    exp_t it;
    int   pos;
    it.due = due; it.tag = tag; it.fv = fv; it.sc = sc; it.ol = ol;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].due > due) begin
        pos = i;
        break;
      end
    end
    q.insert(pos, it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares at the negedge following the due edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.due != cyc) begin
        errors++;
        $display("FAIL %s missed slot actual=%0d expected=%0d", it.tag, cyc, it.due);
      end else if (fault_vec !== it.fv || short_n !== it.sc || open_n !== it.ol) begin
        errors++;
        $display("FAIL %s cyc %0d actual fv=%h sc=%b ol=%b expected fv=%h sc=%b ol=%b",
                 it.tag, cyc, fault_vec, short_n, open_n, it.fv, it.sc, it.ol);
      end
    end
  end

  initial begin
    int c;
    int c2;
    rst = 1'b1; cmp_above = '1; cmd_on = '0; latch_upd = 1'b0;
    step(4);
    rst = 1'b0;
    c = cyc;
    push(c + 1, "R9", 8'h00, 1'b1, 1'b1);
    push(c + 3, "R9", 8'h00, 1'b1, 1'b1);
    step(6);

    // R1: channel 2 on with comparator high
    cmd_on = 8'h04; c = cyc;
    push(c + 1, "R1", 8'h04, 1'b0, 1'b1);
    step(3);

    // R2 / R4: channel 2 off, channel 5 comparator low
    cmd_on = 8'h00; cmp_above[5] = 1'b0; c = cyc;
    push(c + 1, "R6", 8'h00, 1'b1, 1'b1);
    push(c + 4, "R2", 8'h00, 1'b1, 1'b1);
    push(c + 5, "R2", 8'h20, 1'b1, 1'b0);
    step(7);

    // R3 + R4 together
    cmd_on = 8'h04; c = cyc;
    push(c + 1, "R3", 8'h24, 1'b0, 1'b0);
    step(3);

    // R6: channel 7 on with comparator low is healthy
    cmd_on = 8'h84; cmp_above[7] = 1'b0; c = cyc;
    push(c + 1, "R1", 8'hA4, 1'b0, 1'b0);
    push(c + 5, "R6", 8'h24, 1'b0, 1'b0);
    step(7);

    // R8: one-cycle low glitch on off channel 0 is dropped
    cmp_above[0] = 1'b0; c = cyc;
    push(c + 5, "R8", 8'h24, 1'b0, 1'b0);
    push(c + 6, "R8", 8'h24, 1'b0, 1'b0);
    push(c + 7, "R8", 8'h24, 1'b0, 1'b0);
    step(1);
    cmp_above[0] = 1'b1;
    step(9);

    // R8: two-cycle low level passes, then reverts
    cmp_above[0] = 1'b0; c = cyc;
    push(c + 5, "R8", 8'h25, 1'b0, 1'b0);
    push(c + 7, "R8", 8'h24, 1'b0, 1'b0);
    step(2);
    cmp_above[0] = 1'b1;
    step(9);

    // R5: blanking window, open load unaffected
    latch_upd = 1'b1; c = cyc;
    push(c + 1, "R5", 8'h20, 1'b1, 1'b0);
    push(c + BLANK, "R5", 8'h20, 1'b1, 1'b0);
    push(c + BLANK + 1, "R5", 8'h24, 1'b0, 1'b0);
    step(1);
    latch_upd = 1'b0;
    step(BLANK + 4);

    // R7: restart on the last masked cycle of a running window
    latch_upd = 1'b1; c = cyc;
    push(c + 1, "R7", 8'h20, 1'b1, 1'b0);
    step(1);
    latch_upd = 1'b0;
    step(BLANK - 2);
    latch_upd = 1'b1; c2 = cyc;
    push(c2 + 1, "R7", 8'h20, 1'b1, 1'b0);
    push(c + BLANK + 1, "R7", 8'h20, 1'b1, 1'b0);
    push(c2 + BLANK, "R7", 8'h20, 1'b1, 1'b0);
    push(c2 + BLANK + 1, "R7", 8'h24, 1'b0, 1'b0);
    step(1);
    latch_upd = 1'b0;
    step(BLANK + 4);

    while (q.size() > 0) step(1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL WDOG run hung actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule